// File: doc/BRIEF.md
# Memory-to-Memory Copy Engine

This block copies a run of data from one address range to another. Software sets it up through a small register port: a source address, a destination address, a byte count, and a control word. The control word holds the start bit, the interrupt enable, the beat size, and two options that keep the read side or the write side at a fixed address. A fixed address lets the engine drain or fill the single data register of a streaming peripheral.

On the master side the engine works one beat at a time. It issues a read and waits until the read is accepted, which also returns the data. It then issues a write that carries that data. After each completed write the remaining count drops by the beat size. When the count reaches zero the engine goes idle, sets a done flag and, if the interrupt is enabled, holds its interrupt line high until software clears the flag.

A transfer can be aborted at any time by clearing the start bit. The next transfer may use a different beat size or a different fixed-address mode. Neither an abort nor such a change calls for a reset. A soft reset happens only when two control writes in a row both carry the reset bit.

Top module: `dma_engine`

## Requirements
- R1: After hardware reset every register reads zero, `irq` is low, and neither `rdReq` nor `wrReq` is asserted. Register word offsets on `regAddr`: 0 control, 1 status, 2 source, 3 destination, 4 length. Control bits: [0] go (reads back as busy), [1] interrupt enable, [2] fixed read address, [3] fixed write address, [5:4] size, [7] reset. Status bits: [0] busy, [1] done, [2] error.
- R2: A control write with go=1 starts a transfer when the engine is idle and the length is valid. Busy reads 1 until the transfer ends. Each beat's write carries exactly the data returned by that beat's read.
- R3: Size code 0 moves 1 byte per beat, code 1 moves 4, and code 2 moves 8. The length register drops by that amount on each completed write, and the transfer ends in the cycle it reaches zero. `rdSize` and `wrSize` carry the size code.
- R4: After each beat the source and destination addresses advance by the beat size. When control bit 2 is set the read address stays fixed, and when control bit 3 is set the write address stays fixed.
- R5: When a transfer ends, the done flag is set and `irq` equals done AND interrupt enable. Any write to the status register clears done and error, and this drops `irq`.
- R6: A control write with go=0 and reset=0 while busy aborts the transfer. Busy clears, done stays clear, and no further read or write request is issued.
- R7: A go request with length zero, with a length that is not a whole multiple of the beat size, or with size code 3 sets the error flag and starts nothing.
- R8: While busy, writes to the source, destination and length registers are ignored, and so is a control write with go=1. Only the abort write and the reset pair take effect.
- R9: A soft reset happens only on two consecutive register writes that are both control writes with bit 7 set. It clears all registers and stops any transfer. A single such write, or a pair broken by another register write, changes nothing.
- R10: A transfer that follows a completed or aborted transfer finishes and raises its interrupt, even when it uses a different size or a different fixed-address mode, with no reset in between.
- R11: A read or write request stays asserted with stable address until it is accepted. A beat's write is issued only after that beat's read has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr` (combinational) |
| rdReq | output | 1 | Read request, held until `rdAck` |
| rdAddr | output | ADDR_W | Read byte address |
| rdSize | output | 2 | Read beat size code |
| rdAck | input | 1 | Read accepted; `rdData` is valid in the same cycle |
| rdData | input | DATA_W | Read data |
| wrReq | output | 1 | Write request, held until `wrAck` |
| wrAddr | output | ADDR_W | Write byte address |
| wrSize | output | 2 | Write beat size code |
| wrData | output | DATA_W | Write data |
| wrAck | input | 1 | Write accepted |
| irq | output | 1 | Level interrupt: done AND interrupt enable |

## Verification
The bench builds the engine with ADDR_W=16, LEN_W=10 and DATA_W=64. With 16-bit addresses each source address maps to a distinct 64-bit data pattern, so the scoreboard can tell from a write's data exactly which address was read. The 64-bit data path carries doubleword beats without any lane packing. A 10-bit length keeps the invalid-length cases and the multi-beat aborts short. Through the ack-hold control, the bench parks the engine in a known state so that it can abort, write registers while busy, and reset during a transfer.

// File: rtl/dma_pkg.sv
package dma_pkg;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_STAT = 3'd1;
  localparam logic [2:0] REG_SRC  = 3'd2;
  localparam logic [2:0] REG_DST  = 3'd3;
  localparam logic [2:0] REG_LEN  = 3'd4;

  localparam int CB_GO    = 0;
  localparam int CB_IRQEN = 1;
  localparam int CB_FIXRD = 2;
  localparam int CB_FIXWR = 3;
  localparam int CB_SIZE  = 4;
  localparam int CB_RST   = 7;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} engState_e;

  typedef struct packed {
    logic       wrSrc;
    logic       wrDst;
    logic       wrLen;
    logic       clear;
    logic       capture;
    logic       advance;
    logic       active;
    logic       fixRd;
    logic       fixWr;
    logic [3:0] stepBytes;
  } dmaStrobe_t;

  function automatic logic [3:0] stepOf(input logic [1:0] sz);
    case (sz)
      2'd0:    return 4'd1;
      2'd1:    return 4'd4;
      2'd2:    return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobe_t        str,
  input  logic [31:0]       regWdata,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [LEN_W-1:0]  lenCur,
  output logic [DATA_W-1:0] dataHold
);

  logic [ADDR_W-1:0] addrStep;
  logic [LEN_W-1:0]  lenStep;

  assign addrStep = ADDR_W'(str.stepBytes);
  assign lenStep  = LEN_W'(str.stepBytes);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcAddr  <= '0;
      dstAddr  <= '0;
      lenCur   <= '0;
      dataHold <= '0;
    end else if (str.clear) begin
      srcAddr  <= '0;
      dstAddr  <= '0;
      lenCur   <= '0;
      dataHold <= '0;
    end else begin
      if (str.wrSrc) srcAddr <= regWdata[ADDR_W-1:0];
      if (str.wrDst) dstAddr <= regWdata[ADDR_W-1:0];
      if (str.wrLen) lenCur  <= regWdata[LEN_W-1:0];
      if (str.capture) dataHold <= rdData;
      if (str.advance) begin
        if (!str.fixRd) srcAddr <= srcAddr + addrStep;
        if (!str.fixWr) dstAddr <= dstAddr + addrStep;
        lenCur <= lenCur - lenStep;
      end
    end
  end

  // R3: each completed beat removes exactly one beat size from the count
  p_len_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    str.advance && !str.clear |=> lenCur == $past(lenCur) - LEN_W'($past(str.stepBytes)));

  // R4: a fixed read side keeps its address across a beat
  p_fixed_src_r4: assert property (@(posedge clk) disable iff (!rstN)
    str.advance && str.fixRd && !str.clear |=> srcAddr == $past(srcAddr));

  // R4: a fixed write side keeps its address across a beat
  p_fixed_dst_r4: assert property (@(posedge clk) disable iff (!rstN)
    str.advance && str.fixWr && !str.clear |=> dstAddr == $past(dstAddr));

  // R8: with a transfer running, only beats or a soft reset move the source
  p_busy_src_r8: assert property (@(posedge clk) disable iff (!rstN)
    str.active && !str.advance && !str.clear |=> srcAddr == $past(srcAddr));

endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWdata,
  input  logic             rdAck,
  input  logic             wrAck,
  input  logic [LEN_W-1:0] lenCur,
  output dmaStrobe_t       str,
  output logic             rdReq,
  output logic             wrReq,
  output logic [1:0]       xferSize,
  output logic             irq,
  output logic [31:0]      ctrlWord,
  output logic [31:0]      statWord
);

  engState_e  state;
  logic       irqEn, fixRd, fixWr, doneFlag, errFlag, rstArmed;
  logic [1:0] sizeSel;

  logic busy, ctrlWr, statWr, rstBitW, goBitW, doReset, abortReq, setupWr;
  logic lenOk, startOk, startBad, capture, advance, lastBeat;
  logic [1:0] newSize;

  function automatic logic lenFits(input logic [LEN_W-1:0] len, input logic [1:0] sz);
    case (sz)
      2'd0:    return len != '0;
      2'd1:    return (len != '0) && (len[1:0] == 2'b00);
      2'd2:    return (len != '0) && (len[2:0] == 3'b000);
      default: return 1'b0;
    endcase
  endfunction

  assign busy     = (state != ST_IDLE);
  assign ctrlWr   = regWe && (regAddr == REG_CTRL);
  assign statWr   = regWe && (regAddr == REG_STAT);
  assign rstBitW  = regWdata[CB_RST];
  assign goBitW   = regWdata[CB_GO];
  assign newSize  = regWdata[CB_SIZE +: 2];
  assign doReset  = ctrlWr && rstBitW && rstArmed;
  assign abortReq = ctrlWr && !rstBitW && busy && !goBitW;
  assign setupWr  = ctrlWr && !rstBitW && !busy;
  assign lenOk    = lenFits(lenCur, newSize);
  assign startOk  = setupWr && goBitW && lenOk;
  assign startBad = setupWr && goBitW && !lenOk;
  assign capture  = (state == ST_READ) && rdAck;
  assign advance  = (state == ST_WRITE) && wrAck;
  assign lastBeat = advance && (lenCur == LEN_W'(stepOf(sizeSel)));

  always_comb begin
    str           = '0;
    str.wrSrc     = regWe && (regAddr == REG_SRC) && !busy;
    str.wrDst     = regWe && (regAddr == REG_DST) && !busy;
    str.wrLen     = regWe && (regAddr == REG_LEN) && !busy;
    str.clear     = doReset;
    str.capture   = capture && !abortReq;
    str.advance   = advance && !abortReq;
    str.active    = busy;
    str.fixRd     = fixRd;
    str.fixWr     = fixWr;
    str.stepBytes = stepOf(sizeSel);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      irqEn    <= 1'b0;
      fixRd    <= 1'b0;
      fixWr    <= 1'b0;
      sizeSel  <= 2'd0;
      doneFlag <= 1'b0;
      errFlag  <= 1'b0;
      rstArmed <= 1'b0;
    end else if (doReset) begin
      state    <= ST_IDLE;
      irqEn    <= 1'b0;
      fixRd    <= 1'b0;
      fixWr    <= 1'b0;
      sizeSel  <= 2'd0;
      doneFlag <= 1'b0;
      errFlag  <= 1'b0;
      rstArmed <= 1'b0;
    end else begin
      if (regWe) rstArmed <= ctrlWr && rstBitW;
      if (setupWr) begin
        irqEn   <= regWdata[CB_IRQEN];
        fixRd   <= regWdata[CB_FIXRD];
        fixWr   <= regWdata[CB_FIXWR];
        sizeSel <= newSize;
      end
      if (statWr) begin
        doneFlag <= 1'b0;
        errFlag  <= 1'b0;
      end
      if (startBad) errFlag <= 1'b1;
      if (lastBeat && !abortReq) doneFlag <= 1'b1;
      if (abortReq) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE:  if (startOk) state <= ST_READ;
          ST_READ:  if (rdAck) state <= ST_WRITE;
          ST_WRITE: if (wrAck) state <= lastBeat ? ST_IDLE : ST_READ;
          default:  state <= ST_IDLE;
        endcase
      end
    end
  end

  assign rdReq    = (state == ST_READ);
  assign wrReq    = (state == ST_WRITE);
  assign xferSize = sizeSel;
  assign irq      = doneFlag && irqEn;
  assign ctrlWord = {24'd0, 2'b00, sizeSel, fixWr, fixRd, irqEn, busy};
  assign statWord = {29'd0, errFlag, doneFlag, busy};

  // R11: an unaccepted read stays requested unless the transfer is stopped
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !rdAck && !abortReq && !doReset |=> rdReq);

  // R11: an unaccepted write stays requested unless the transfer is stopped
  p_wr_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    wrReq && !wrAck && !abortReq && !doReset |=> wrReq);

  // R11: a write request only begins right after an accepted read
  p_wr_after_rd_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrReq) |-> $past(rdReq && rdAck));

  // R5: done only appears as the write phase ends
  p_done_at_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $past(state == ST_WRITE) && !busy);

  // R7: a rejected start leaves the engine idle
  p_err_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> !busy && !rdReq);

  // R6: an abort write leaves the engine idle next cycle
  p_abort_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> !busy && !rdReq && !wrReq);

  // R9: the second reset write returns the control fields to zero
  p_reset_pair_r9: assert property (@(posedge clk) disable iff (!rstN)
    doReset |=> !busy && !irqEn && !doneFlag && sizeSel == 2'd0);

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [1:0]        rdSize,
  input  logic              rdAck,
  input  logic [DATA_W-1:0] rdData,
  output logic              wrReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [1:0]        wrSize,
  output logic [DATA_W-1:0] wrData,
  input  logic              wrAck,
  output logic              irq
);

  dmaStrobe_t        str;
  logic [ADDR_W-1:0] srcAddr, dstAddr;
  logic [LEN_W-1:0]  lenCur;
  logic [1:0]        xferSize;
  logic [31:0]       ctrlWord, statWord;

  dma_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .rdAck(rdAck), .wrAck(wrAck), .lenCur(lenCur), .str(str), .rdReq(rdReq),
    .wrReq(wrReq), .xferSize(xferSize), .irq(irq), .ctrlWord(ctrlWord), .statWord(statWord)
  );

  dma_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_datapath (
    .clk(clk), .rstN(rstN), .str(str), .regWdata(regWdata), .rdData(rdData),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .lenCur(lenCur), .dataHold(wrData)
  );

  assign rdAddr = srcAddr;
  assign wrAddr = dstAddr;
  assign rdSize = xferSize;
  assign wrSize = xferSize;

  always_comb begin
    case (regAddr)
      REG_CTRL: regRdata = ctrlWord;
      REG_STAT: regRdata = statWord;
      REG_SRC:  regRdata = 32'(srcAddr);
      REG_DST:  regRdata = 32'(dstAddr);
      REG_LEN:  regRdata = 32'(lenCur);
      default:  regRdata = 32'd0;
    endcase
  end

endmodule

// File: tb/dma_engine_tb.sv
module dma_engine_tb;
  localparam int AW = 16;
  localparam int DW = 64;
  localparam int LW = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic rdReq, wrReq, irq;
  logic rdAck = 1'b0, wrAck = 1'b0;
  logic [AW-1:0] rdAddr, wrAddr;
  logic [1:0] rdSize, wrSize;
  logic [DW-1:0] rdData = '0, wrData;

  int checks = 0, fails = 0, popped = 0, cyc = 0;
  bit holdAcks = 1'b0;

  typedef struct { logic [AW-1:0] addr; logic [DW-1:0] data; logic [1:0] sz; } expItem_t;
  expItem_t expQ[$];

  always #4 clk = ~clk;

  dma_engine #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW)) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .rdReq(rdReq), .rdAddr(rdAddr), .rdSize(rdSize), .rdAck(rdAck),
    .rdData(rdData), .wrReq(wrReq), .wrAddr(wrAddr), .wrSize(wrSize), .wrData(wrData),
    .wrAck(wrAck), .irq(irq)
  );

  function automatic logic [DW-1:0] memWord(input logic [AW-1:0] a);
    return {a, ~a, a ^ 16'h5A5A, a + 16'h1111};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic expectXfer(input logic [AW-1:0] src, input logic [AW-1:0] dst, input int len,
                            input logic [1:0] sz, input bit fr, input bit fw);
    int step;
    step = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 4 : 8;
    for (int i = 0; i < len / step; i++) begin
      expItem_t it;
      it.addr = fw ? dst : dst + AW'(i * step);
      it.data = memWord(fr ? src : src + AW'(i * step));
      it.sz   = sz;
      expQ.push_back(it);
    end
  endtask

  task automatic waitIdle(input string req);
    logic [31:0] s;
    s = 32'd1;
    for (int i = 0; i < 400 && s[0]; i++) rdReg(3'd1, s);
    check(s[0] == 1'b0, req, "engine idle", 64'(s), 64'(0));
    check(expQ.size() == 0, req, "all expected beats written", 64'(expQ.size()), 64'(0));
  endtask

  // memory responder and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      rdData = memWord(rdAddr);
      rdAck  = rdReq && !holdAcks && (cyc % 3 != 0);
      wrAck  = wrReq && !holdAcks && (cyc % 2 == 0);
      if (wrAck) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2", "unexpected write", 64'(wrAddr), 64'(0));
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          popped++;
          check(wrAddr == e.addr, "R4", "write address", 64'(wrAddr), 64'(e.addr));
          check(wrData == e.data, "R2", "write data", wrData, e.data);
          check(wrSize == e.sz && rdSize == e.sz, "R3", "beat size", 64'(wrSize), 64'(e.sz));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", "run did not finish", 64'(cyc), 64'(0));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdReg(3'd1, r); check(r == 0, "R1", "status after reset", 64'(r), 0);
    rdReg(3'd0, r); check(r == 0, "R1", "control after reset", 64'(r), 0);
    rdReg(3'd4, r); check(r == 0, "R1", "length after reset", 64'(r), 0);
    check(!irq && !rdReq && !wrReq, "R1", "outputs idle", 64'({irq, rdReq, wrReq}), 0);

    // byte transfer, both sides advancing
    wrReg(3'd2, 32'h100); wrReg(3'd3, 32'h200); wrReg(3'd4, 32'd4);
    expectXfer(16'h100, 16'h200, 4, 2'd0, 0, 0);
    wrReg(3'd0, 32'h03);
    waitIdle("R2");
    rdReg(3'd1, r); check(r == 32'h2, "R5", "done after byte run", 64'(r), 64'h2);
    check(irq == 1'b1, "R5", "irq after byte run", 64'(irq), 1);
    rdReg(3'd4, r); check(r == 0, "R3", "length counted to zero", 64'(r), 0);
    rdReg(3'd2, r); check(r == 32'h104, "R4", "source advanced", 64'(r), 64'h104);
    rdReg(3'd3, r); check(r == 32'h204, "R4", "dest advanced", 64'(r), 64'h204);
    wrReg(3'd1, 32'h0);
    check(irq == 1'b0, "R5", "irq cleared by status write", 64'(irq), 0);

    // word transfer with fixed write address; register writes while busy
    holdAcks = 1'b1;
    wrReg(3'd2, 32'h300); wrReg(3'd3, 32'h40); wrReg(3'd4, 32'd12);
    expectXfer(16'h300, 16'h40, 12, 2'd1, 0, 1);
    wrReg(3'd0, 32'h1B);
    rdReg(3'd1, r); check(r[0] == 1'b1, "R2", "busy after go", 64'(r), 1);
    check(rdReq && !wrReq, "R11", "read held, no write before read", 64'({rdReq, wrReq}), 64'h2);
    wrReg(3'd3, 32'h999); wrReg(3'd4, 32'd100); wrReg(3'd0, 32'h11);
    rdReg(3'd3, r); check(r == 32'h40, "R8", "dest write ignored while busy", 64'(r), 64'h40);
    rdReg(3'd0, r); check(r == 32'h1B, "R8", "control write ignored while busy", 64'(r), 64'h1B);
    check(rdReq, "R11", "read still held", 64'(rdReq), 1);
    holdAcks = 1'b0;
    waitIdle("R8");
    check(irq == 1'b1, "R10", "irq after size change to word", 64'(irq), 1);
    wrReg(3'd1, 32'h0);

    // doubleword transfer with fixed read address
    wrReg(3'd2, 32'h500); wrReg(3'd3, 32'h600); wrReg(3'd4, 32'd16);
    expectXfer(16'h500, 16'h600, 16, 2'd2, 1, 0);
    wrReg(3'd0, 32'h27);
    waitIdle("R10");
    check(irq == 1'b1, "R10", "irq after switch to fixed read", 64'(irq), 1);
    rdReg(3'd2, r); check(r == 32'h500, "R4", "fixed source unchanged", 64'(r), 64'h500);
    wrReg(3'd1, 32'h0);

    // invalid lengths
    wrReg(3'd0, 32'h03);
    rdReg(3'd1, r); check(r == 32'h4, "R7", "zero length error", 64'(r), 64'h4);
    check(!rdReq, "R7", "no read on zero length", 64'(rdReq), 0);
    wrReg(3'd1, 32'h0);
    wrReg(3'd4, 32'd6); wrReg(3'd0, 32'h13);
    rdReg(3'd1, r); check(r == 32'h4, "R7", "misaligned length error", 64'(r), 64'h4);
    wrReg(3'd1, 32'h0);
    wrReg(3'd4, 32'd8); wrReg(3'd0, 32'h33);
    rdReg(3'd1, r); check(r == 32'h4, "R7", "size code 3 error", 64'(r), 64'h4);
    check(!rdReq && !wrReq, "R7", "nothing started", 64'({rdReq, wrReq}), 0);
    wrReg(3'd1, 32'h0);

    // abort mid-transfer
    wrReg(3'd2, 32'h800); wrReg(3'd3, 32'h900); wrReg(3'd4, 32'd40);
    popped = 0;
    expectXfer(16'h800, 16'h900, 40, 2'd0, 0, 0);
    wrReg(3'd0, 32'h03);
    repeat (12) @(negedge clk);
    holdAcks = 1'b1;
    repeat (3) @(negedge clk);
    wrReg(3'd0, 32'h02);
    rdReg(3'd1, r); check(r == 0, "R6", "abort clears busy, no done", 64'(r), 0);
    check(!irq, "R6", "no irq after abort", 64'(irq), 0);
    holdAcks = 1'b0;
    repeat (6) @(negedge clk);
    check(!rdReq && !wrReq, "R6", "no requests after abort", 64'({rdReq, wrReq}), 0);
    check(popped > 0 && popped < 10, "R6", "partial beats before abort", 64'(popped), 64'(5));
    expQ.delete();

    // new size and mode after abort, no reset
    wrReg(3'd2, 32'hA00); wrReg(3'd3, 32'hB00); wrReg(3'd4, 32'd8);
    expectXfer(16'hA00, 16'hB00, 8, 2'd2, 0, 0);
    wrReg(3'd0, 32'h23);
    waitIdle("R10");
    check(irq == 1'b1, "R10", "irq after abort and size change", 64'(irq), 1);
    wrReg(3'd1, 32'h0);

    // soft reset pairing
    wrReg(3'd0, 32'h80);
    rdReg(3'd2, r); check(r == 32'hA08, "R9", "single reset write no effect", 64'(r), 64'hA08);
    rdReg(3'd0, r); check(r == 32'h22, "R9", "control kept after single write", 64'(r), 64'h22);
    wrReg(3'd2, 32'h55); wrReg(3'd0, 32'h80);
    rdReg(3'd2, r); check(r == 32'h55, "R9", "broken pair no effect", 64'(r), 64'h55);
    wrReg(3'd0, 32'h80);
    rdReg(3'd2, r); check(r == 0, "R9", "pair clears source", 64'(r), 0);
    rdReg(3'd0, r); check(r == 0, "R9", "pair clears control", 64'(r), 0);

    // soft reset during a transfer
    holdAcks = 1'b1;
    wrReg(3'd2, 32'h10); wrReg(3'd3, 32'h20); wrReg(3'd4, 32'd40);
    wrReg(3'd0, 32'h03);
    rdReg(3'd1, r); check(r[0] == 1'b1, "R9", "busy before reset", 64'(r), 1);
    wrReg(3'd0, 32'h80); wrReg(3'd0, 32'h80);
    rdReg(3'd1, r); check(r == 0, "R9", "reset stops transfer", 64'(r), 0);
    rdReg(3'd4, r); check(r == 0, "R9", "reset clears length", 64'(r), 0);
    check(!rdReq && !wrReq, "R9", "no requests after reset", 64'({rdReq, wrReq}), 0);
    holdAcks = 1'b0;
    repeat (4) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule